// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a countdown timer driven by a programmable power-of-two prescaler. Three configuration registers sit behind a small write port. The first is an initial count, the second is a timer control entry, and the third is a 4-bit divide setting. Writing the initial count loads the counter and starts it. Each prescaled tick then lowers the count by one. The current count, the stored divide setting and a one-cycle interrupt request are driven on output ports.

When the count reaches zero, the timer issues an interrupt request that carries the vector held in the control entry, unless the entry's mask bit is set. In one-shot mode the counter then stays at zero. In periodic mode it spends one tick at zero and then reloads the initial count, so one period is initial count + 1 ticks. An initial count of zero leaves the timer idle. Decoding of a wider register space and delivery of the request to an interrupt controller belong to the surrounding logic.

Top module: `divided_countdown_timer`

## Requirements
- R1: A write with `cfg_sel` = 2 keeps only bits 0, 1 and 3 of `cfg_wdata[3:0]` in the divide register, which reads back on `div_cfg`; bit 2 always reads 0.
- R2: The divide code is {div_cfg[3], div_cfg[1:0]}, and the shift is (code + 1) mod 8, so code 7 divides by 1. Let k be the number of clock cycles since the initial-count write took effect. The elapsed tick count is then k >> shift.
- R3: In one-shot mode, `cur_count` equals max(N − elapsed, 0) for initial count N, and it stays at 0 after that.
- R4: In periodic mode, `cur_count` equals N − (elapsed mod (N + 1)).
- R5: When a tick brings the count to 0, `irq_valid` goes high for exactly one cycle and `irq_vector` shows entry bits [7:0]. This happens once in one-shot mode and once per period in periodic mode.
- R6: When the entry's mask bit (bit 16) is 1, the timer raises no interrupt request, and counting carries on as normal.
- R7: Entry bit 17 selects periodic mode when it is 1 and one-shot mode when it is 0.
- R8: A write with `cfg_sel` = 0 sets `cur_count` to the written value on the following cycle and restarts the prescaler phase.
- R9: An initial count of 0 holds `cur_count` at 0 and raises no interrupt request.
- R10: A write to the entry (`cfg_sel` = 1) or to the divide register leaves the count and the prescaler phase unchanged. The new setting takes effect from the next tick onwards.
- R11: A write with `cfg_sel` = 3 has no effect.
- R12: After reset, `cur_count` is 0, `div_cfg` is 0, `irq_valid` is 0, and the entry is masked and in one-shot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 initial count, 1 entry, 2 divide, 3 unused |
| cfg_wdata | input | DATA_W | Write data |
| cur_count | output | COUNT_W | Current count |
| div_cfg | output | 4 | Stored divide setting |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector carried by the request |

## Verification
The bench builds the block with COUNT_W = 8, DATA_W = 32 and VEC_W = 8. At this width, all eight divide codes can be run in both modes, with and without the mask, for several initial counts including 0 and 1. Every cycle of at least two full periods is compared against an arithmetic model. A narrow count also keeps the runs at shift 7 short. Further directed cases check that an entry write or a divide write does not restart the prescaler, by finding the exact cycle of the next tick.

// File: rtl/dct_pkg.sv
// Package: shared constants and helpers for the divided countdown timer.
// Assumes a 2-bit register select and an entry word at least 18 bits wide.
package dct_pkg;

    localparam int MAX_SHIFT   = 7;
    localparam int PRESC_W     = MAX_SHIFT;
    localparam int ENT_MASK_B  = 16;
    localparam int ENT_PER_B   = 17;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_ENTRY = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // Divide shift from the stored setting: code {b3,b1,b0}, plus one, modulo 8.
    function automatic logic [2:0] div_shift(input logic [3:0] cfg);
        return 3'({cfg[3], cfg[1:0]} + 3'd1);
    endfunction

endpackage

// File: rtl/dct_cfg_regs.sv
// Module: configuration registers of the timer.
// Holds the initial count, the entry fields (vector, mask, mode) and the
// divide setting. It produces a load strobe on an initial-count write.
// Assumes COUNT_W <= DATA_W and VEC_W <= 16.
module dct_cfg_regs #(
    parameter int DATA_W  = 32,
    parameter int COUNT_W = 32,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [1:0]         sel_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               load_o,
    output logic [COUNT_W-1:0] load_val_o,
    output logic [COUNT_W-1:0] init_o,
    output logic [3:0]         div_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               mask_o,
    output logic               periodic_o
);
    import dct_pkg::*;

    logic [COUNT_W-1:0] init_q;
    logic [3:0]         div_q;
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q;
    logic               per_q;

    // Load strobe and the value it carries, straight from the write port.
    always_comb begin
        load_o     = wr_en_i && (sel_i == SEL_INIT);
        load_val_o = wdata_i[COUNT_W-1:0];
    end

    // Register updates; the unused select writes nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            div_q  <= 4'd0;
            vec_q  <= '0;
            mask_q <= 1'b1;
            per_q  <= 1'b0;
        end else if (wr_en_i) begin
            case (sel_i)
                SEL_INIT:  init_q <= wdata_i[COUNT_W-1:0];
                SEL_ENTRY: begin
                    vec_q  <= wdata_i[VEC_W-1:0];
                    mask_q <= wdata_i[ENT_MASK_B];
                    per_q  <= wdata_i[ENT_PER_B];
                end
                SEL_DIV:   div_q <= wdata_i[3:0] & 4'b1011;
                default:   ;
            endcase
        end
    end

    assign init_o     = init_q;
    assign div_o      = div_q;
    assign vec_o      = vec_q;
    assign mask_o     = mask_q;
    assign periodic_o = per_q;

    assert_div_bit2_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_DIV) |=> (div_q[2] == 1'b0 && div_q[3] == $past(wdata_i[3])));

    assert_none_sel_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_NONE) |=> ($stable(div_q) && $stable(init_q) && $stable(vec_q)));

endmodule

// File: rtl/dct_prescaler.sv
// Module: power-of-two prescaler.
// Counts base cycles from the last load and raises a tick whenever the low
// 'shift' bits of that count are all ones. Shift 0 ticks on every cycle.
// The phase is cleared only by a load, so a shift change never restarts it.
module dct_prescaler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       run_i,
    input  logic [2:0] shift_i,
    output logic       tick_o
);
    import dct_pkg::*;

    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] low_mask;

    // Mask that selects the phase bits which must all be ones for a tick.
    always_comb begin
        low_mask = ~({PRESC_W{1'b1}} << shift_i);
        tick_o   = run_i && !load_i && ((phase_q & low_mask) == low_mask);
    end

    // Phase counter: cleared on load, advanced while the timer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (load_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && shift_i != 3'd0) |=> (!tick_o || shift_i == 3'd0));

endmodule

// File: rtl/dct_counter.sv
// Module: down-counter and interrupt request.
// Loads the initial count and lowers it on each tick. On the tick that
// reaches zero it raises a one-cycle request unless masked. In periodic mode
// it reloads on the tick after zero; in one-shot mode it stops at zero.
module dct_counter #(
    parameter int COUNT_W = 32,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [COUNT_W-1:0] load_val_i,
    input  logic [COUNT_W-1:0] init_i,
    input  logic               tick_i,
    input  logic               periodic_i,
    input  logic               mask_i,
    input  logic [VEC_W-1:0]   vec_i,
    output logic               run_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   irq_vec_o
);
    logic [COUNT_W-1:0] cnt_q;
    logic               run_q;
    logic               irq_q;
    logic [VEC_W-1:0]   ivec_q;

    // Count, run state and request update on load or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            irq_q  <= 1'b0;
            ivec_q <= '0;
        end else begin
            irq_q <= 1'b0;
            if (load_i) begin
                cnt_q <= load_val_i;
                run_q <= (load_val_i != '0);
            end else if (tick_i) begin
                if (cnt_q > COUNT_W'(1)) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (cnt_q == COUNT_W'(1)) begin
                    cnt_q  <= '0;
                    irq_q  <= !mask_i;
                    ivec_q <= vec_i;
                    if (!periodic_i) run_q <= 1'b0;
                end else if (periodic_i) begin
                    cnt_q <= init_i;
                end else begin
                    run_q <= 1'b0;
                end
            end
        end
    end

    assign run_o     = run_q;
    assign count_o   = cnt_q;
    assign irq_o     = irq_q;
    assign irq_vec_o = ivec_q;

    assert_irq_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == '0 && $past(cnt_q) != '0));

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !$past(mask_i));

    assert_oneshot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !periodic_i && !load_i) |=> (cnt_q == '0));

    assert_within_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= init_i));

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/divided_countdown_timer.sv
// Module: top of the divided countdown timer.
// Joins the configuration registers, the prescaler and the down-counter.
// Assumes one register write per cycle and a single clock domain.
module divided_countdown_timer #(
    parameter int DATA_W  = 32,
    parameter int COUNT_W = 32,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [1:0]         cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [COUNT_W-1:0] cur_count,
    output logic [3:0]         div_cfg,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector
);
    import dct_pkg::*;

    logic               load;
    logic [COUNT_W-1:0] load_val;
    logic [COUNT_W-1:0] init_val;
    logic [3:0]         div_val;
    logic [VEC_W-1:0]   vec_val;
    logic               mask_val;
    logic               per_val;
    logic               running;
    logic               tick;
    logic [2:0]         shift;

    // Shift decoded from the stored divide setting.
    always_comb shift = div_shift(div_val);

    dct_cfg_regs #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .VEC_W(VEC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_wr_en), .sel_i(cfg_sel),
        .wdata_i(cfg_wdata), .load_o(load), .load_val_o(load_val),
        .init_o(init_val), .div_o(div_val), .vec_o(vec_val),
        .mask_o(mask_val), .periodic_o(per_val)
    );

    dct_prescaler presc_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(running),
        .shift_i(shift), .tick_o(tick)
    );

    dct_counter #(.COUNT_W(COUNT_W), .VEC_W(VEC_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
        .init_i(init_val), .tick_i(tick), .periodic_i(per_val),
        .mask_i(mask_val), .vec_i(vec_val), .run_o(running),
        .count_o(cur_count), .irq_o(irq_valid), .irq_vec_o(irq_vector)
    );

    assign div_cfg = div_val;

    assert_zero_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (!running && cur_count == '0));

endmodule

// File: tb/divided_countdown_timer_tb_top.sv
module divided_countdown_timer_tb_top;
    localparam int DATA_W  = 32;
    localparam int COUNT_W = 8;
    localparam int VEC_W   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr_en = 1'b0;
    logic [1:0]         cfg_sel = 2'd0;
    logic [DATA_W-1:0]  cfg_wdata = '0;
    logic [COUNT_W-1:0] cur_count;
    logic [3:0]         div_cfg;
    logic               irq_valid;
    logic [VEC_W-1:0]   irq_vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    divided_countdown_timer #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cur_count(cur_count), .div_cfg(div_cfg),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Writes one register; returns at the negedge right after the capturing edge.
    task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] d);
        cfg_sel   = sel;
        cfg_wdata = d;
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    function automatic int model(input int n, input bit per, input int e);
        if (n == 0) return 0;
        if (per) return n - (e % (n + 1));
        return (e >= n) ? 0 : n - e;
    endfunction

    function automatic int shift_of(input int c);
        return ((((c >> 1) & 4) | (c & 3)) + 1) & 7;
    endfunction

    // One sweep case: configure, load, then compare every cycle to the model.
    task automatic run_case(input int cfg, input bit per, input bit msk, input int n, input int vec);
        int s;
        int kmax;
        int prev;
        int cur;
        s = shift_of(cfg);
        wr(2'd2, DATA_W'(cfg));
        wr(2'd1, DATA_W'(vec) | (DATA_W'(msk) << 16) | (DATA_W'(per) << 17));
        wr(2'd0, DATA_W'(n));
        check("R8 load value", int'(cur_count), n);
        kmax = (n == 0) ? 40 : (((2 * n + 3) << s) + 3);
        prev = n;
        for (int k = 1; k <= kmax; k++) begin
            @(negedge clk);
            cur = model(n, per, k >> s);
            check(per ? "R4 R7 periodic count" : "R3 R2 one-shot count", int'(cur_count), cur);
            if (n == 0) check("R9 idle no request", int'(irq_valid), 0);
            else if (msk) check("R6 masked no request", int'(irq_valid), 0);
            else check("R5 request pulse", int'(irq_valid), (cur == 0 && prev != 0) ? 1 : 0);
            if (irq_valid && cur == 0 && prev != 0)
                check("R5 request vector", int'(irq_vector), vec);
            prev = cur;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset count", int'(cur_count), 0);
        check("R12 reset divide", int'(div_cfg), 0);
        check("R12 reset request", int'(irq_valid), 0);
        // R12: reset entry masked, one-shot: load 2 at shift 0 and expect no request
        wr(2'd2, 32'hB);
        wr(2'd0, 32'd2);
        repeat (4) begin
            @(negedge clk);
            check("R12 reset entry masked", int'(irq_valid), 0);
        end
        check("R12 reset entry one-shot", int'(cur_count), 0);

        // R1 divide bit filtering
        wr(2'd2, 32'hFFFF_FFFF);
        check("R1 divide keeps 0,1,3", int'(div_cfg), 11);
        wr(2'd2, 32'h4);
        check("R1 divide bit 2 dropped", int'(div_cfg), 0);

        // R2..R9 sweep over all codes
        for (int c = 0; c < 16; c++) begin
            if (c[2]) continue;
            run_case(c, 1'b0, 1'b0, 3, 8'h40 + c);
            run_case(c, 1'b1, 1'b0, 2, 8'h80 + c);
        end
        for (int c = 8; c < 12; c++) begin
            run_case(c, 1'b1, 1'b1, 3, 8'h11);
            run_case(c, 1'b1, 1'b0, 1, 8'h22);
            run_case(c, 1'b0, 1'b0, 0, 8'h33);
        end
        run_case(11, 1'b1, 1'b0, 255, 8'hA5);

        // R10: entry and divide writes keep count and prescaler phase
        wr(2'd2, 32'hA);
        wr(2'd0, 32'd100);
        check("R8 load", int'(cur_count), 100);
        wr(2'd1, 32'h0000_0077);
        check("R10 entry write keeps count", int'(cur_count), 100);
        wr(2'd2, 32'h9);
        check("R10 divide write keeps count", int'(cur_count), 100);
        repeat (61) @(negedge clk);
        check("R10 no tick before phase 64", int'(cur_count), 100);
        @(negedge clk);
        check("R10 tick at phase 64", int'(cur_count), 99);

        // R11: unused select ignored
        wr(2'd3, 32'hFFFF_FFFF);
        check("R11 divide unchanged", int'(div_cfg), 9);
        check("R11 count unchanged", int'(cur_count), 99);
        check("R11 no request", int'(irq_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule